// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside a small processor core and decides when the core's clock runs. The core issues a one-cycle power-save command that carries a mode bit. Mode 1 selects Idle. Mode 0 selects Sleep, or Deep Sleep if the deep arm bit was set just before the command. While any low-power state is active, the CPU clock enable is held low. The system clock and the peripherals are not touched.

Idle and Sleep end on an enabled interrupt or a watchdog timeout. An interrupt that lands in the same cycle as the command is parked until entry is complete, and is then released. Deep Sleep ignores ordinary interrupts. It ends only on a power-on event, the master-clear pin, the deep watchdog, an enabled RTC alarm, or a fresh edge on the external wake pin. The causes of each Deep Sleep exit are recorded in a status register that software can read and overwrite.

The core reaches the block through a small write port. Address 0 holds the arm bit and address 1 holds the wake-source status. Arming is deliberately fragile: it lapses unless a mode-0 command follows at once.

Top module: `lp_seq`

## Requirements
- R1: After reset, pwr_state_o is 0 (run), cpu_clk_en_o is 1, and arm_o, wake_src_o, wdt_clr_o and irq_release_o are all 0.
- R2: A ps_cmd_i with ps_mode_i=1 in run state has two effects in the next cycle. pwr_state_o becomes 1 (Idle) and cpu_clk_en_o goes to 0. wdt_clr_o is high for exactly that one cycle.
- R3: In Idle (1) or Sleep (2), pwr_state_o returns to 0 one cycle after either of two events. The first is any bit set in both irq_req_i and irq_en_i. The second is wdt_timeout_i. A request whose enable bit is clear does not wake the block.
- R4: Suppose an enabled interrupt is present in the same cycle as a command to enter Idle or Sleep. Entry still completes: the next cycle shows state 1 or 2 with cpu_clk_en_o=0. In that cycle irq_release_o is 1, and in the cycle after it the state is 0.
- R5: A write to address 0 with data bit 0 set makes arm_o 1 in the next cycle. Arming lapses unless a mode-0 command arrives within ARM_WIN cycles of arm_o rising. With ARM_WIN=1, a command two cycles after the write finds arm_o at 0. A write to address 0 with bit 0 clear also clears arm_o, and so does an Idle command.
- R6: A write that sets the arm bit clears every bit of wake_src_o. A write to address 1 loads wake_src_o with wr_data_i.
- R7: A mode-0 command with arm_o=1 enters Deep Sleep (state 3). A mode-0 command with arm_o=0 enters Sleep (state 2). arm_o stays 1 for the whole of Deep Sleep.
- R8: Deep Sleep exits to state 0 one cycle after any of these: por_i high, mclr_ni low, dswdt_timeout_i high, or rtc_alarm_i high while rtc_en_i is high. Interrupts and wdt_timeout_i do not end Deep Sleep.
- R9: On a Deep Sleep exit, wake_src_o records every cause present in the exit cycle. The bits are: bit 0 power-on, bit 1 master clear, bit 2 deep watchdog, bit 3 RTC alarm, bit 4 external pin. arm_o is cleared in the same cycle.
- R10: The external pin counts as asserted when ext_int_i equals ext_pol_i. It wakes Deep Sleep only if ext_en_i was high in the entry cycle. It also needs a change from deasserted to asserted while in Deep Sleep, so a level already asserted at entry does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: arm bit, 1: wake-source status |
| wr_data_i | input | 5 | Write data |
| ps_cmd_i | input | 1 | One-cycle power-save command |
| ps_mode_i | input | 1 | 0: Sleep / Deep Sleep, 1: Idle |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Per-interrupt enables |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| dswdt_timeout_i | input | 1 | Deep-sleep watchdog timeout |
| por_i | input | 1 | Power-on event |
| mclr_ni | input | 1 | Master clear pin, active low |
| rtc_alarm_i | input | 1 | RTC alarm |
| rtc_en_i | input | 1 | RTC enabled |
| ext_int_i | input | 1 | External wake pin |
| ext_pol_i | input | 1 | Asserted level of the external pin |
| ext_en_i | input | 1 | External pin wake enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| irq_release_o | output | 1 | Release of a deferred interrupt |
| arm_o | output | 1 | Deep Sleep arm bit |
| pwr_state_o | output | 2 | 0 run, 1 Idle, 2 Sleep, 3 Deep Sleep |
| wake_src_o | output | 5 | Latched Deep Sleep wake causes |

## Verification
The bench builds the block with N_IRQ=4 and ARM_WIN=1. The narrow interrupt vector lets random request and enable masks hit the no-overlap case often, which tests that a request with its enable clear does not wake the block. With the one-cycle window, the lapse of the arm bit can be seen directly: the bench issues the command one cycle too late and confirms the block lands in Sleep rather than Deep Sleep. Random draws of the Deep Sleep causes, including draws where several causes coincide, check that every cause in the exit cycle is recorded together.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_DEEP  = 2'd3
  } pwr_state_e;

  localparam int unsigned SRC_W     = 5;
  localparam int unsigned SRC_POR   = 0;
  localparam int unsigned SRC_MCLR  = 1;
  localparam int unsigned SRC_DSWDT = 2;
  localparam int unsigned SRC_RTC   = 3;
  localparam int unsigned SRC_EXT   = 4;

  localparam logic MODE_SLEEP = 1'b0;
  localparam logic MODE_IDLE  = 1'b1;
  localparam logic ADDR_ARM   = 1'b0;
  localparam logic ADDR_SRC   = 1'b1;
endpackage

// File: rtl/lpseq_arm.sv
module lpseq_arm #(
  parameter int unsigned ARM_WIN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic in_run_i,
  input  logic cmd_deep_i,
  input  logic cmd_idle_i,
  input  logic deep_exit_i,
  output logic arm_o
);
  localparam int unsigned CW = (ARM_WIN < 2) ? 1 : $clog2(ARM_WIN);
  localparam logic [CW-1:0] LAST = CW'(ARM_WIN - 1);

  logic          arm_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (set_i) begin
      arm_q <= 1'b1;
      cnt_q <= '0;
    end else if (clr_i || deep_exit_i) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm_q && in_run_i && !cmd_deep_i) begin
      // window expires unless a mode-0 command consumes it
      if (cmd_idle_i || cnt_q == LAST) begin
        arm_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign arm_o = arm_q;

  // R5
  arm_lapse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && in_run_i && !cmd_deep_i && !set_i && cnt_q == LAST) |=> !arm_q);
endmodule

// File: rtl/lpseq_wake.sv
module lpseq_wake
  import lpseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_deep_i,
  input  logic             enter_deep_i,
  input  logic             por_i,
  input  logic             mclr_ni,
  input  logic             dswdt_i,
  input  logic             rtc_alarm_i,
  input  logic             rtc_en_i,
  input  logic             ext_i,
  input  logic             ext_pol_i,
  input  logic             ext_en_i,
  output logic [SRC_W-1:0] cause_o
);
  logic ext_act;
  logic ext_prev_q;
  logic ext_arm_q;

  assign ext_act = (ext_i == ext_pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q <= 1'b0;
      ext_arm_q  <= 1'b0;
    end else begin
      ext_prev_q <= ext_act;
      if (enter_deep_i)   ext_arm_q <= ext_en_i;
      else if (!in_deep_i) ext_arm_q <= 1'b0;
    end
  end

  always_comb begin
    cause_o            = '0;
    cause_o[SRC_POR]   = por_i;
    cause_o[SRC_MCLR]  = !mclr_ni;
    cause_o[SRC_DSWDT] = dswdt_i;
    cause_o[SRC_RTC]   = rtc_alarm_i && rtc_en_i;
    cause_o[SRC_EXT]   = ext_arm_q && ext_act && !ext_prev_q;
    if (!in_deep_i) cause_o = '0;
  end

  // R8
  rtc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtc_en_i |-> !cause_o[SRC_RTC]);
  // R10
  ext_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o[SRC_EXT] |=> ext_prev_q);
endmodule

// File: rtl/lpseq_fsm.sv
module lpseq_fsm
  import lpseq_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ps_cmd_i,
  input  logic             ps_mode_i,
  input  logic             arm_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wdt_to_i,
  input  logic             deep_wake_i,
  output pwr_state_e       state_o,
  output logic             held_o,
  output logic             wdt_clr_o,
  output logic             enter_deep_o,
  output logic             cmd_idle_o
);
  pwr_state_e state_q, state_d;
  logic held_q, wdt_clr_q;
  logic irq_hit, cmd_go;

  assign irq_hit = |(irq_req_i & irq_en_i);
  assign cmd_go  = ps_cmd_i && (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (cmd_go) begin
        if (ps_mode_i == MODE_IDLE) state_d = ST_IDLE;
        else if (arm_i)             state_d = ST_DEEP;
        else                        state_d = ST_SLEEP;
      end
      ST_IDLE, ST_SLEEP: if (held_q || irq_hit || wdt_to_i) state_d = ST_RUN;
      ST_DEEP: if (deep_wake_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      held_q    <= 1'b0;
      wdt_clr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      // interrupt coincident with entry waits until entry is done
      held_q    <= cmd_go && irq_hit && (state_d != ST_DEEP);
      wdt_clr_q <= cmd_go && (ps_mode_i == MODE_IDLE);
    end
  end

  assign state_o      = state_q;
  assign held_o       = held_q;
  assign wdt_clr_o    = wdt_clr_q;
  assign enter_deep_o = cmd_go && (ps_mode_i == MODE_SLEEP) && arm_i;
  assign cmd_idle_o   = cmd_go && (ps_mode_i == MODE_IDLE);

  // R2
  idle_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ps_cmd_i && ps_mode_i) |=> (wdt_clr_q && state_q == ST_IDLE));
  // R3
  light_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q inside {ST_IDLE, ST_SLEEP}) && (irq_hit || wdt_to_i)) |=> state_q == ST_RUN);
  // R4
  held_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> (state_q != ST_RUN) ##1 (state_q == ST_RUN));
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lpseq_pkg::*;
#(
  parameter int unsigned N_IRQ   = 8,
  parameter int unsigned ARM_WIN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [SRC_W-1:0] wr_data_i,
  input  logic             ps_cmd_i,
  input  logic             ps_mode_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wdt_timeout_i,
  input  logic             dswdt_timeout_i,
  input  logic             por_i,
  input  logic             mclr_ni,
  input  logic             rtc_alarm_i,
  input  logic             rtc_en_i,
  input  logic             ext_int_i,
  input  logic             ext_pol_i,
  input  logic             ext_en_i,
  output logic             cpu_clk_en_o,
  output logic             wdt_clr_o,
  output logic             irq_release_o,
  output logic             arm_o,
  output logic [1:0]       pwr_state_o,
  output logic [SRC_W-1:0] wake_src_o
);
  pwr_state_e       state;
  logic             arm, held, enter_deep, cmd_idle;
  logic             arm_set, arm_clr, src_wr, in_deep, deep_exit;
  logic [SRC_W-1:0] cause;
  logic [SRC_W-1:0] src_q;

  assign arm_set   = wr_en_i && (wr_addr_i == ADDR_ARM) && wr_data_i[0];
  assign arm_clr   = wr_en_i && (wr_addr_i == ADDR_ARM) && !wr_data_i[0];
  assign src_wr    = wr_en_i && (wr_addr_i == ADDR_SRC);
  assign in_deep   = (state == ST_DEEP);
  assign deep_exit = in_deep && (|cause);

  lpseq_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ps_cmd_i     (ps_cmd_i),
    .ps_mode_i    (ps_mode_i),
    .arm_i        (arm),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .wdt_to_i     (wdt_timeout_i),
    .deep_wake_i  (deep_exit),
    .state_o      (state),
    .held_o       (held),
    .wdt_clr_o    (wdt_clr_o),
    .enter_deep_o (enter_deep),
    .cmd_idle_o   (cmd_idle)
  );

  lpseq_arm #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (arm_set),
    .clr_i       (arm_clr),
    .in_run_i    (state == ST_RUN),
    .cmd_deep_i  (enter_deep),
    .cmd_idle_i  (cmd_idle),
    .deep_exit_i (deep_exit),
    .arm_o       (arm)
  );

  lpseq_wake u_wake (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_deep_i    (in_deep),
    .enter_deep_i (enter_deep),
    .por_i        (por_i),
    .mclr_ni      (mclr_ni),
    .dswdt_i      (dswdt_timeout_i),
    .rtc_alarm_i  (rtc_alarm_i),
    .rtc_en_i     (rtc_en_i),
    .ext_i        (ext_int_i),
    .ext_pol_i    (ext_pol_i),
    .ext_en_i     (ext_en_i),
    .cause_o      (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        src_q <= '0;
    else if (arm_set)   src_q <= '0;
    else if (src_wr)    src_q <= wr_data_i;
    else if (deep_exit) src_q <= src_q | cause;
  end

  assign cpu_clk_en_o  = (state == ST_RUN);
  assign irq_release_o = held && (state != ST_RUN);
  assign arm_o         = arm;
  assign pwr_state_o   = state;
  assign wake_src_o    = src_q;

  // R7
  deep_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_deep |-> arm);
  // R9
  deep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_exit |=> (cpu_clk_en_o && !arm && ((src_q & $past(cause)) == $past(cause))));
  // R6
  arm_src_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_set |=> (src_q == '0));
endmodule

// File: tb/lp_seq_tb.sv
module lp_seq_tb;
  localparam int unsigned N_IRQ = 4;
  localparam int unsigned ARM_WIN = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, wr_addr, ps_cmd, ps_mode;
  logic [4:0] wr_data;
  logic [N_IRQ-1:0] irq_req, irq_en;
  logic wdt_to, dswdt_to, por, mclr_n, rtc_alarm, rtc_en, ext_int, ext_pol, ext_en;
  logic cpu_clk_en, wdt_clr, irq_rel, arm;
  logic [1:0] pstate;
  logic [4:0] wsrc;

  lp_seq #(.N_IRQ(N_IRQ), .ARM_WIN(ARM_WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ps_cmd_i(ps_cmd), .ps_mode_i(ps_mode),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .wdt_timeout_i(wdt_to),
    .dswdt_timeout_i(dswdt_to), .por_i(por), .mclr_ni(mclr_n),
    .rtc_alarm_i(rtc_alarm), .rtc_en_i(rtc_en), .ext_int_i(ext_int),
    .ext_pol_i(ext_pol), .ext_en_i(ext_en), .cpu_clk_en_o(cpu_clk_en),
    .wdt_clr_o(wdt_clr), .irq_release_o(irq_rel), .arm_o(arm),
    .pwr_state_o(pstate), .wake_src_o(wsrc)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic a, logic [4:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cmd(logic m);
    ps_cmd = 1'b1; ps_mode = m;
    step();
    ps_cmd = 1'b0;
  endtask

  task automatic enter_deep(string rq);
    wr(1'b0, 5'h01);
    cmd(1'b0);
    chk(rq, pstate, 2'd3);
  endtask

  function automatic logic exp_wake(logic [N_IRQ-1:0] r, logic [N_IRQ-1:0] e, logic w);
    return (|(r & e)) | w;
  endfunction

  function automatic logic [4:0] exp_src(logic p, logic mn, logic d, logic ra, logic re);
    return {1'b0, ra & re, d, ~mn, p};
  endfunction

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; ps_cmd = 0; ps_mode = 0;
    irq_req = 0; irq_en = 0; wdt_to = 0; dswdt_to = 0; por = 0; mclr_n = 1;
    rtc_alarm = 0; rtc_en = 0; ext_int = 0; ext_pol = 1; ext_en = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 state", pstate, 2'd0);
    chk("R1 clk", cpu_clk_en, 1'b1);
    chk("R1 arm", arm, 1'b0);
    chk("R1 src", wsrc, 5'h00);
    chk("R1 pulses", {wdt_clr, irq_rel}, 2'b00);

    // R2 idle entry and watchdog clear
    cmd(1'b1);
    chk("R2 state", pstate, 2'd1);
    chk("R2 clk", cpu_clk_en, 1'b0);
    chk("R2 wdtclr", wdt_clr, 1'b1);
    step();
    chk("R2 wdtclr pulse", wdt_clr, 1'b0);
    chk("R3 stays idle", pstate, 2'd1);
    wdt_to = 1'b1; step(); wdt_to = 1'b0;
    chk("R3 wdt wake", pstate, 2'd0);

    // R3 random idle wakes
    for (int i = 0; i < 24; i++) begin
      logic [N_IRQ-1:0] r, e;
      logic w, ex;
      cmd(1'b1);
      r = N_IRQ'($urandom); e = N_IRQ'($urandom); w = ($urandom % 4) == 0;
      ex = exp_wake(r, e, w);
      irq_req = r; irq_en = e; wdt_to = w;
      step();
      irq_req = 0; irq_en = 0; wdt_to = 0;
      chk("R3 random wake", pstate, ex ? 2'd0 : 2'd1);
      chk("R3 clk", cpu_clk_en, ex);
      if (!ex) begin
        wdt_to = 1'b1; step(); wdt_to = 1'b0;
        chk("R3 wdt wake", pstate, 2'd0);
      end
    end

    // R4 coincident interrupt with idle and sleep entry
    for (int m = 1; m >= 0; m--) begin
      irq_req = 4'b0100; irq_en = 4'b0100;
      cmd(m[0]);
      irq_req = 0; irq_en = 0; #1;
      chk("R4 entered", pstate, m[0] ? 2'd1 : 2'd2);
      chk("R4 clk gated", cpu_clk_en, 1'b0);
      chk("R4 release", irq_rel, 1'b1);
      step();
      chk("R4 woke", pstate, 2'd0);
      chk("R4 release end", irq_rel, 1'b0);
    end

    // R6 status write, arm clears status
    wr(1'b1, 5'h15);
    chk("R6 src write", wsrc, 5'h15);
    wr(1'b0, 5'h01);
    chk("R6 arm clears src", wsrc, 5'h00);
    chk("R5 arm set", arm, 1'b1);
    // R5 command two cycles late lapses
    step();
    chk("R5 arm lapsed", arm, 1'b0);
    cmd(1'b0);
    chk("R7 sleep when unarmed", pstate, 2'd2);
    irq_req = 4'b0001; irq_en = 4'b0001; step(); irq_req = 0; irq_en = 0;
    chk("R3 sleep wake", pstate, 2'd0);
    // R5 clear by write and by idle command
    wr(1'b0, 5'h01);
    wr(1'b0, 5'h00);
    chk("R5 write clear", arm, 1'b0);
    wr(1'b0, 5'h01);
    cmd(1'b1);
    chk("R5 idle clears arm", arm, 1'b0);
    wdt_to = 1'b1; step(); wdt_to = 1'b0;

    // R7 / R8 deep entry and non-waking events
    enter_deep("R7 deep entry");
    chk("R7 arm held", arm, 1'b1);
    irq_req = '1; irq_en = '1; wdt_to = 1'b1; rtc_alarm = 1'b1; rtc_en = 1'b0;
    step();
    chk("R8 irq/wdt/rtc-off ignored", pstate, 2'd3);
    irq_req = 0; irq_en = 0; wdt_to = 0; rtc_alarm = 0;
    mclr_n = 1'b0; step(); mclr_n = 1'b1;
    chk("R8 mclr wake", pstate, 2'd0);
    chk("R9 mclr bit", wsrc, 5'h02);
    chk("R9 arm cleared", arm, 1'b0);

    // R8 / R9 random cause mixes
    for (int i = 0; i < 20; i++) begin
      logic p, mn, d, ra, re;
      logic [4:0] ex;
      enter_deep("R7 deep entry");
      p = ($urandom % 3) == 0; mn = ($urandom % 3) != 0; d = ($urandom % 3) == 0;
      ra = $urandom; re = $urandom;
      ex = exp_src(p, mn, d, ra, re);
      por = p; mclr_n = mn; dswdt_to = d; rtc_alarm = ra; rtc_en = re;
      step();
      por = 0; mclr_n = 1; dswdt_to = 0; rtc_alarm = 0; rtc_en = 0;
      chk("R8 cause wake", pstate, (ex != 0) ? 2'd0 : 2'd3);
      if (ex != 0) chk("R9 cause bits", wsrc, ex);
      else begin
        dswdt_to = 1'b1; step(); dswdt_to = 1'b0;
        chk("R9 dswdt bit", wsrc, 5'h04);
      end
    end

    // R9 simultaneous causes
    enter_deep("R7 deep entry");
    por = 1; dswdt_to = 1; step(); por = 0; dswdt_to = 0;
    chk("R9 multi", wsrc, 5'h05);

    // R10 level present at entry does not wake
    ext_pol = 1; ext_en = 1; ext_int = 1;
    enter_deep("R10 entry");
    step(); step();
    chk("R10 level ignored", pstate, 2'd3);
    ext_int = 0; step();
    chk("R10 deassert", pstate, 2'd3);
    ext_int = 1; step();
    chk("R10 edge wake", pstate, 2'd0);
    chk("R10 bit", wsrc, 5'h10);

    // R10 low polarity
    ext_pol = 0; ext_int = 1;
    enter_deep("R10 entry");
    ext_int = 0; step();
    chk("R10 low pol wake", wsrc, 5'h10);

    // R10 enable captured at entry
    ext_en = 0; ext_int = 1;
    enter_deep("R10 entry");
    ext_en = 1; step();
    ext_int = 0; step();
    chk("R10 late enable ignored", pstate, 2'd3);
    mclr_n = 0; step(); mclr_n = 1;
    chk("R10 mclr after", wsrc, 5'h02);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule